// File: doc/BRIEF.md
# M23 Tributary Multiplexer and Demultiplexer

This block merges seven DS2 tributary bit streams into the payload of a DS3 M-frame and splits a received DS3 stream back into seven DS2 streams. Each tributary feeds the transmit side through a small bit FIFO with a valid/ready handshake. Tributary clocks run at nominal rather than exact rates, so the transmitter uses bit stuffing per tributary. One stuff opportunity exists per tributary per M-frame. The stuff decision is signalled through three control bits in that tributary's subframe.

Transmit emits one bit per clock. It also flags the overhead positions, which a separate framer overwrites with its own alignment, parity and spare bits. The block fills only the stuff-control positions itself. Receive takes the aligned DS3 bit stream and a frame-start marker from a synchronizer. It takes a majority of the three control bits and uses the result to decide whether the stuff opportunity holds data or filler. Each tributary bit is delivered with an enable pulse.

Top module: `m23_muxdemux`

## Requirements
- R1: An M-frame has 4760 bits: 7 subframes (s = 0..6), each of 8 blocks (b = 0..7), and each block is 1 overhead bit followed by 84 payload bits. `tx_oh` is high exactly on overhead bits. `tx_mf_start` is high exactly on bit 0 of subframe 0.
- R2: Payload bit k (0..83) of every block belongs to tributary floor(k/12). Seven 12-bit slots follow in tributary order 0 to 6.
- R3: Each tributary has a FIFO of FIFO_DEPTH bits. `trib_in_ready[j]` is high while its fill is below FIFO_DEPTH. A bit is accepted on a clock where valid and ready are both high.
- R4: At the first overhead bit of subframe s (block 0), tributary s is marked for stuffing when its fill is below FIFO_DEPTH/2, counted before that clock's write.
- R5: The overhead bits of blocks 2, 4 and 6 in subframe s carry tributary s's stuff mark: all 1 when it is stuffing, all 0 otherwise. Every other overhead bit is sent as 0.
- R6: The stuff opportunity of tributary s is payload bit 12*s of block 7 in subframe s. When stuffing, that bit is sent as 0 and no FIFO bit is consumed.
- R7: A data slot whose FIFO is empty is sent as 0 and consumes nothing.
- R8: Tributary bits leave in the order they were accepted. Each transmit output is registered, so it describes the position counted one clock earlier.
- R9: `rx_mf_start` marks the current `rx_bit` as bit 0 of an M-frame and realigns the counter at any time. No enable is produced before the first marker.
- R10: Each received payload bit raises `trib_out_en` for its owning tributary one clock later, with the bit on `trib_out_data`. Overhead bits raise no enable.
- R11: When two or more of the three control bits of subframe s were 1, the stuff opportunity of tributary s is discarded and raises no enable. Otherwise it is delivered as data.
- R12: During reset, all transmit and receive outputs are 0 and every `trib_in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trib_in_data | input | 7 | One data bit per transmit tributary |
| trib_in_valid | input | 7 | Bit offered per tributary |
| trib_in_ready | output | 7 | FIFO has room per tributary |
| tx_bit | output | 1 | Multiplexed DS3 bit |
| tx_oh | output | 1 | Current tx bit is an overhead position |
| tx_mf_start | output | 1 | Current tx bit is the first bit of an M-frame |
| rx_bit | input | 1 | Received aligned DS3 bit |
| rx_mf_start | input | 1 | Current rx bit is the first of an M-frame |
| trib_out_data | output | 7 | Demultiplexed bit per tributary |
| trib_out_en | output | 7 | Tributary bit valid strobe |

## Verification
Some properties are checked on every clock. Each FIFO stays within its depth, and at most one tributary is read per clock. A read with no write lowers the fill by exactly one. An inserted stuff bit goes out as 0. A frame start always falls on an overhead bit. Receive raises at most one enable per clock, and a discarded stuff bit is followed by no enable. Other behaviour can only be shown against the bench's model over whole frames: the stuff decision taken from the fill, the control-bit values, bit ordering through the FIFOs, the majority vote across all eight control patterns, and realignment by a mid-frame marker.

// File: rtl/m23_pkg.sv
package m23_pkg;
  localparam int NTRIB     = 7;
  localparam int SLOT_BITS = 12;
  localparam int NBLK      = 8;
  localparam int PAY_BITS  = NTRIB * SLOT_BITS;
  localparam int BLK_BITS  = PAY_BITS + 1;
  localparam int SUB_W     = $clog2(NTRIB);
  localparam int BLK_W     = $clog2(NBLK);
  localparam int POS_W     = $clog2(BLK_BITS);

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [BLK_W-1:0] blk;
    logic [POS_W-1:0] bitn;
  } frame_pos_t;

  // overhead bit of a block that carries a stuff-control bit
  function automatic logic is_ctrl_slot(frame_pos_t p);
    return (p.bitn == '0) &&
           (p.blk == BLK_W'(2) || p.blk == BLK_W'(4) || p.blk == BLK_W'(6));
  endfunction

  // tributary owning a payload bit (bitn >= 1)
  function automatic logic [SUB_W-1:0] slot_owner(frame_pos_t p);
    logic [POS_W-1:0] k;
    k = p.bitn - POS_W'(1);
    return SUB_W'(k / POS_W'(SLOT_BITS));
  endfunction

  // first bit of the subframe owner's slot in the last block
  function automatic logic is_stuff_opp(frame_pos_t p);
    return (p.blk == BLK_W'(NBLK - 1)) &&
           (p.bitn == POS_W'(p.sub) * POS_W'(SLOT_BITS) + POS_W'(1));
  endfunction

  function automatic frame_pos_t pos_advance(frame_pos_t p);
    frame_pos_t n;
    n = p;
    if (p.bitn == POS_W'(BLK_BITS - 1)) begin
      n.bitn = '0;
      if (p.blk == BLK_W'(NBLK - 1)) begin
        n.blk = '0;
        n.sub = (p.sub == SUB_W'(NTRIB - 1)) ? '0 : p.sub + SUB_W'(1);
      end else begin
        n.blk = p.blk + BLK_W'(1);
      end
    end else begin
      n.bitn = p.bitn + POS_W'(1);
    end
    return n;
  endfunction
endpackage

// File: rtl/m23_poscnt.sv
module m23_poscnt
  import m23_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  output frame_pos_t pos
);
  frame_pos_t cnt;

  assign pos = restart ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= pos_advance(pos);
  end
endmodule

// File: rtl/m23_bitfifo.sv
module m23_bitfifo #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       din,
  input  logic                       pop,
  output logic                       dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= ptr_inc(wr_ptr);
      end
      if (pop) rd_ptr <= ptr_inc(rd_ptr);
      if (push && !pop)      fill <= fill + FW'(1);
      else if (pop && !push) fill <= fill - FW'(1);
    end
  end
endmodule

// File: rtl/m23_rx_demux.sv
module m23_rx_demux
  import m23_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_mf_start,
  output logic [NTRIB-1:0] out_data,
  output logic [NTRIB-1:0] out_en,
  output logic             drop,
  output logic [1:0]       votes
);
  frame_pos_t       rp;
  logic             locked, lock_now, data_slot;
  logic [SUB_W-1:0] owner;

  m23_poscnt u_rxpos (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rx_mf_start),
    .pos     (rp)
  );

  assign data_slot = (rp.bitn != '0);
  assign owner     = slot_owner(rp);
  assign lock_now  = locked | rx_mf_start;
  assign drop      = data_slot && is_stuff_opp(rp) && (votes >= 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      votes    <= '0;
      out_en   <= '0;
      out_data <= '0;
    end else begin
      locked <= lock_now;
      if (!data_slot && rp.blk == '0)      votes <= '0;
      else if (is_ctrl_slot(rp) && rx_bit) votes <= votes + 2'd1;
      for (int j = 0; j < NTRIB; j++) begin
        out_en[j] <= lock_now && data_slot && (owner == SUB_W'(j)) && !drop;
        if (lock_now && data_slot && (owner == SUB_W'(j)) && !drop)
          out_data[j] <= rx_bit;
      end
    end
  end
endmodule

// File: rtl/m23_muxdemux.sv
module m23_muxdemux
  import m23_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIB-1:0] trib_in_data,
  input  logic [NTRIB-1:0] trib_in_valid,
  output logic [NTRIB-1:0] trib_in_ready,
  output logic             tx_bit,
  output logic             tx_oh,
  output logic             tx_mf_start,
  input  logic             rx_bit,
  input  logic             rx_mf_start,
  output logic [NTRIB-1:0] trib_out_data,
  output logic [NTRIB-1:0] trib_out_en
);
  localparam int FILL_W = $clog2(FIFO_DEPTH + 1);
  localparam int HALF   = FIFO_DEPTH / 2;

  frame_pos_t                   tx_pos;
  logic [NTRIB-1:0]             fifo_push, tx_pop, fifo_head;
  logic [NTRIB-1:0][FILL_W-1:0] fill;
  logic                         stuff_q, stuff_ins, tx_data_slot;
  logic [SUB_W-1:0]             tx_owner;
  logic                         rx_drop;
  logic [1:0]                   rx_votes;

  m23_poscnt u_txpos (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .pos     (tx_pos)
  );

  assign tx_data_slot = (tx_pos.bitn != '0);
  assign tx_owner     = slot_owner(tx_pos);
  assign stuff_ins    = tx_data_slot && is_stuff_opp(tx_pos) && stuff_q;

  generate
    for (genvar j = 0; j < NTRIB; j++) begin : g_trib
      assign trib_in_ready[j] = fill[j] < FILL_W'(FIFO_DEPTH);
      assign fifo_push[j]     = trib_in_valid[j] && trib_in_ready[j];
      assign tx_pop[j]        = tx_data_slot && (tx_owner == SUB_W'(j)) &&
                                !stuff_ins && (fill[j] != '0);
      m23_bitfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push[j]),
        .din   (trib_in_data[j]),
        .pop   (tx_pop[j]),
        .dout  (fifo_head[j]),
        .fill  (fill[j])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stuff_q     <= 1'b0;
      tx_bit      <= 1'b0;
      tx_oh       <= 1'b0;
      tx_mf_start <= 1'b0;
    end else begin
      if (!tx_data_slot && tx_pos.blk == '0)
        stuff_q <= fill[tx_pos.sub] < FILL_W'(HALF);
      tx_oh       <= !tx_data_slot;
      tx_mf_start <= (tx_pos == '0);
      if (is_ctrl_slot(tx_pos)) tx_bit <= stuff_q;
      else if (|tx_pop)         tx_bit <= fifo_head[tx_owner];
      else                      tx_bit <= 1'b0;
    end
  end

  m23_rx_demux u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_bit      (rx_bit),
    .rx_mf_start (rx_mf_start),
    .out_data    (trib_out_data),
    .out_en      (trib_out_en),
    .drop        (rx_drop),
    .votes       (rx_votes)
  );
endmodule

// File: rtl/m23_checker.sv
module m23_checker
  import m23_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NTRIB-1:0]                      tx_pop,
  input logic [NTRIB-1:0]                      fifo_push,
  input logic [NTRIB-1:0][$clog2(DEPTH+1)-1:0] fill,
  input logic                                  stuff_ins,
  input logic                                  tx_bit,
  input logic                                  tx_oh,
  input logic                                  tx_mf_start,
  input logic                                  rx_drop,
  input logic [NTRIB-1:0]                      trib_out_en
);
  localparam int FW = $clog2(DEPTH + 1);

  assert_one_reader_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_pop));

  generate
    for (genvar j = 0; j < NTRIB; j++) begin : g_fifo_chk
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill[j] <= FW'(DEPTH));
      assert_pop_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop[j] && !fifo_push[j]) |=> (fill[j] == $past(fill[j]) - FW'(1)));
    end
  endgenerate

  assert_stuff_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_ins |=> !tx_bit);

  assert_start_on_oh_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mf_start |-> tx_oh);

  assert_single_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_out_en));

  assert_drop_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> (trib_out_en == '0));
endmodule

bind m23_muxdemux m23_checker #(.DEPTH(FIFO_DEPTH)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_pop      (tx_pop),
  .fifo_push   (fifo_push),
  .fill        (fill),
  .stuff_ins   (stuff_ins),
  .tx_bit      (tx_bit),
  .tx_oh       (tx_oh),
  .tx_mf_start (tx_mf_start),
  .rx_drop     (rx_drop),
  .trib_out_en (trib_out_en)
);

// File: tb/m23_muxdemux_bench.sv
module m23_muxdemux_bench;
  localparam int NT     = 7;
  localparam int DEPTH  = 8;
  localparam int FRAME  = 4760;
  localparam int SUBLEN = 680;
  localparam int BLKLEN = 85;
  localparam int NCYC   = 60000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [NT-1:0] trib_in_data, trib_in_valid, trib_in_ready;
  logic          tx_bit, tx_oh, tx_mf_start;
  logic          rx_bit, rx_mf_start;
  logic [NT-1:0] trib_out_data, trib_out_en;

  m23_muxdemux #(.FIFO_DEPTH(DEPTH)) u_m23_muxdemux (
    .clk(clk), .rst_n(rst_n),
    .trib_in_data(trib_in_data), .trib_in_valid(trib_in_valid),
    .trib_in_ready(trib_in_ready),
    .tx_bit(tx_bit), .tx_oh(tx_oh), .tx_mf_start(tx_mf_start),
    .rx_bit(rx_bit), .rx_mf_start(rx_mf_start),
    .trib_out_data(trib_out_data), .trib_out_en(trib_out_en)
  );

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model state
  bit    txq[NT][$];
  int    tl = 0, rl = 0, gl = 1500, cpat = 0, votes = 0;
  bit    stuff = 0, locked = 0;
  int    n_stuff = 0, n_nostuff = 0, n_drop = 0, n_keep = 0;
  bit    e_bit, e_oh, e_mf;
  string e_tag, r_tag;
  bit    e_en[NT], e_dat[NT];
  int    rate[NT] = '{9, 13, 16, 40, 14, 100, 6};

  task automatic model_tx(input bit [NT-1:0] v, input bit [NT-1:0] d);
    int s, b, k, j;
    bit rdy[NT];
    s = tl / SUBLEN; b = (tl % SUBLEN) / BLKLEN; k = tl % BLKLEN;
    for (int i = 0; i < NT; i++) rdy[i] = txq[i].size() < DEPTH;
    e_mf = (tl == 0);
    e_oh = (k == 0);
    if (k == 0) begin
      if (b == 0) begin
        stuff = txq[s].size() < DEPTH / 2;           // R4
        if (stuff) n_stuff++; else n_nostuff++;
      end
      if (b == 2 || b == 4 || b == 6) begin e_bit = stuff; e_tag = "R4 R5"; end
      else begin e_bit = 0; e_tag = "R5"; end
    end else begin
      j = (k - 1) / 12;
      if (b == 7 && j == s && k - 1 == 12 * s && stuff) begin
        e_bit = 0; e_tag = "R6";
      end else if (txq[j].size() > 0) begin
        e_bit = txq[j].pop_front(); e_tag = "R2 R8";
      end else begin
        e_bit = 0; e_tag = "R7";
      end
    end
    for (int i = 0; i < NT; i++) if (v[i] && rdy[i]) txq[i].push_back(d[i]);
    tl = (tl + 1) % FRAME;
  endtask

  task automatic model_rx(input bit bt, input bit st);
    int s, b, k, j, l;
    bit drop;
    l = st ? 0 : rl;
    if (st) locked = 1;
    s = l / SUBLEN; b = (l % SUBLEN) / BLKLEN; k = l % BLKLEN;
    for (int i = 0; i < NT; i++) e_en[i] = 0;
    r_tag = locked ? "R10" : "R9";
    if (k == 0) begin
      if (b == 0) votes = 0;
      else if (b == 2 || b == 4 || b == 6) votes += bt;
    end else begin
      j = (k - 1) / 12;
      drop = (b == 7 && j == s && k - 1 == 12 * s && votes >= 2);
      if (b == 7 && j == s && k - 1 == 12 * s) begin
        r_tag = "R11";
        if (locked) begin if (drop) n_drop++; else n_keep++; end
      end
      if (locked && !drop) begin e_en[j] = 1; e_dat[j] = bt; end
    end
    rl = (l + 1) % FRAME;
  endtask

  initial begin : watchdog
    #(2_000_000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit [NT-1:0] v, d;
    bit gb, gs;
    int gs_b, gs_k;
    rst_n = 0; trib_in_data = '0; trib_in_valid = '0; rx_bit = 0; rx_mf_start = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(tx_bit == 0 && tx_oh == 0 && tx_mf_start == 0, "R12 tx outputs", {tx_bit, tx_oh, tx_mf_start}, 0);
    chk(trib_out_en == '0, "R12 rx enables", trib_out_en, 0);
    chk(trib_in_ready == '1, "R12 ready", trib_in_ready, 7'h7f);
    rst_n = 1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      for (int i = 0; i < NT; i++) begin
        v[i] = ($urandom % 100) < rate[i];
        if (i == 4 && cyc < 15000) v[i] = 0;         // idle tributary drains (R7)
        d[i] = $urandom % 2;
      end
      if (cyc == 30000) gl = 0;                       // early realignment (R9)
      gs   = (gl == 0) && (cyc > 100);
      gs_b = (gl % SUBLEN) / BLKLEN;
      gs_k = gl % BLKLEN;
      if (gs_k == 0 && gs_b == 0) cpat = $urandom % 8;
      if (gs_k == 0 && (gs_b == 2 || gs_b == 4 || gs_b == 6))
        gb = (cpat >> ((gs_b - 2) / 2)) & 1;
      else
        gb = $urandom % 2;
      gl = (gl + 1) % FRAME;
      model_tx(v, d);
      model_rx(gb, gs);
      trib_in_valid = v; trib_in_data = d; rx_bit = gb; rx_mf_start = gs;
      @(negedge clk);
      chk(tx_bit == e_bit, e_tag, tx_bit, e_bit);
      chk(tx_oh == e_oh && tx_mf_start == e_mf, "R1", {tx_oh, tx_mf_start}, {e_oh, e_mf});
      for (int i = 0; i < NT; i++) begin
        chk(trib_in_ready[i] == (txq[i].size() < DEPTH), "R3", trib_in_ready[i], txq[i].size() < DEPTH);
        chk(trib_out_en[i] == e_en[i], r_tag, trib_out_en[i], e_en[i]);
        if (e_en[i]) chk(trib_out_data[i] == e_dat[i], "R10 data", trib_out_data[i], e_dat[i]);
      end
    end
    chk(n_stuff > 0, "R4 stuff seen", n_stuff, 1);
    chk(n_nostuff > 0, "R4 no-stuff seen", n_nostuff, 1);
    chk(n_drop > 0, "R11 drop seen", n_drop, 1);
    chk(n_keep > 0, "R11 keep seen", n_keep, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule